// File: doc/BRIEF.md
# Up-Counting Timer with Update-Event Control

The block is a general-purpose up-counting timer. The kernel clock is first divided by a programmable prescaler. Each prescaled tick then advances a 16-bit counter. When the counter reaches the active reload value it wraps to zero. Software reaches the block through a plain register port. The port has a synchronous write strobe with address and data, and a combinational read path addressed separately.

An overflow, or a software update request, can raise an update event. The update event is the only moment at which the buffered prescaler value, and optionally a buffered reload value, are copied into the working registers. Software can suppress update events altogether, or restrict them to counter overflow. The update event shows on a one-cycle output pulse and sets a sticky flag, which software clears by writing to it. If software enables it, the flag is also mirrored into bit 31 of the counter read value.

In single-pulse operation the timer switches itself off at its next update event. A free-running sampling strobe divides the kernel clock by 1, 2 or 4 for neighbouring filter logic. Every port is a plain control or status pin with no handshake: each write is accepted in the cycle it is presented, and nothing can stall.

Top module: `tmr_upcount`

## Requirements
- R1: After reset, all of the following hold: the control register (address 0) reads 0, the status register (address 1) reads 0, the counter (address 5) reads 0, the reload register (address 4) reads 0xFFFF, and `upd_pulse_o` is low.
- R2: Control bit 0 (run) gates counting. While run is 0, the counter and the prescaler hold. While run is 1, the counter advances by one on each prescaled tick, which comes every (prescaler value + 1) kernel cycles. A write to address 5 loads the counter directly.
- R3: On a tick where the counter equals the active reload value, the counter wraps to 0. That overflow raises an update event, shown as a one-cycle `upd_pulse_o` in the following cycle.
- R4: With control bit 1 (update-off) set, no update event occurs: no pulse, no flag, and the active prescaler and reload values are unchanged.
- R5: Writing 1 to bit 0 of address 2 is a software update request. It clears the counter and the prescaler count even when update-off is set. It raises an update event only when control bits 1 and 2 are both 0.
- R6: With control bit 2 (overflow-only) set, only counter overflow raises an update event and sets the flag.
- R7: With control bit 3 (single) set, the update event clears the run bit in the same edge, so the counter stops at 0.
- R8: With control bit 4 (reload-buffer) clear, a write to address 4 takes effect at once. With it set, the written value waits in the buffer until the next update event.
- R9: A prescaler write (address 3) reaches the active divider only at an update event.
- R10: Control bits 6:5 select the `sample_tick_o` period: 1, 2 or 4 kernel cycles for codes 0, 1 and 2. Code 3 behaves as code 0.
- R11: Status bit 0 (flag) is set by each update event. Writing 1 to bit 0 of address 1 clears it. If both happen in the same cycle, the set wins.
- R12: With control bit 7 (mirror) set, a counter read carries the flag in bit 31. With mirror clear, bit 31 of a counter read is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Combinational read data |
| upd_pulse_o | output | 1 | One-cycle update-event pulse |
| flag_o | output | 1 | Sticky update flag |
| sample_tick_o | output | 1 | Sampling strobe from the clock divider |

## Verification
The hardest case to reach from the ports is a software update request issued while update-off is set and a buffered reload value is still pending. The counter must restart, but the buffered value must not move and the flag must stay clear. Directed writes set up that state with the timer stopped, and the following reads show counter and status. Random stimulus keeps the prescaler and reload values small, so that overflow, single-pulse self-stop and buffer transfers happen often and collide with register writes in the same cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_EVENT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_PSC    = 3'd3;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd5;

  typedef struct packed {
    logic       mirror;
    logic [1:0] div;
    logic       rl_buf;
    logic       single;
    logic       ovf_only;
    logic       upd_off;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic         load_act,
  input  logic [W-1:0] pre_val,
  output logic         tick
);
  logic [W-1:0] act_q, cnt_q;

  assign tick = run && !restart && (cnt_q == act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      cnt_q <= '0;
    end else begin
      if (load_act) act_q <= pre_val;
      if (restart)       cnt_q <= '0;
      else if (run) begin
        if (cnt_q == act_q) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic         cnt_wr,
  input  logic [W-1:0] cnt_wdata,
  input  logic         rl_wr,
  input  logic [W-1:0] rl_wdata,
  input  logic         rl_buf,
  input  logic         load_act,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rl_pre,
  output logic         ovf
);
  localparam logic [W-1:0] RL_RST = '1;

  logic [W-1:0] cnt_q, pre_q, act_q;

  assign ovf    = tick && !cnt_wr && (cnt_q == act_q);
  assign cnt    = cnt_q;
  assign rl_pre = pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= RL_RST;
      act_q <= RL_RST;
    end else begin
      if (restart)     cnt_q <= '0;
      else if (cnt_wr) cnt_q <= cnt_wdata;
      else if (tick)   cnt_q <= (cnt_q == act_q) ? '0 : cnt_q + 1'b1;

      if (rl_wr) pre_q <= rl_wdata;

      if (rl_wr && !rl_buf) act_q <= rl_wdata;
      else if (load_act)    act_q <= pre_q;
    end
  end
endmodule

// File: rtl/tmr_sample_div.sv
module tmr_sample_div (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] code,
  output logic       tick
);
  logic [1:0] ph_q;
  logic [1:0] lim;

  always_comb begin
    case (code)
      2'd1:    lim = 2'd1;
      2'd2:    lim = 2'd3;
      default: lim = 2'd0;
    endcase
  end

  assign tick = (ph_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ph_q <= '0;
    else if (tick) ph_q <= '0;
    else           ph_q <= ph_q + 1'b1;
  end
endmodule

// File: rtl/tmr_upcount.sv
module tmr_upcount
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              upd_pulse_o,
  output logic              flag_o,
  output logic              sample_tick_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic             flag_q, upd_q;
  logic [CNT_W-1:0] psc_pre_q;
  logic             sw_upd, cnt_wr, rl_wr, tick, ovf, upd_ev;
  logic [CNT_W-1:0] cnt, rl_pre;
  logic             unused_hi;

  assign unused_hi = ^wr_data[DW-1:CNT_W];

  assign sw_upd = wr_en && (wr_addr == A_EVENT) && wr_data[0];
  assign cnt_wr = wr_en && (wr_addr == A_COUNT);
  assign rl_wr  = wr_en && (wr_addr == A_RELOAD);
  assign upd_ev = !ctrl_q.upd_off && (ovf || (sw_upd && !ctrl_q.ovf_only));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      flag_q    <= 1'b0;
      upd_q     <= 1'b0;
      psc_pre_q <= '0;
    end else begin
      upd_q <= upd_ev;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
      else if (ctrl_q.single && upd_ev) ctrl_q.run <= 1'b0;
      if (upd_ev) flag_q <= 1'b1;
      else if (wr_en && wr_addr == A_STATUS && wr_data[0]) flag_q <= 1'b0;
      if (wr_en && wr_addr == A_PSC) psc_pre_q <= wr_data[CNT_W-1:0];
    end
  end

  tmr_prescaler #(.W(CNT_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .restart(sw_upd),
    .load_act(upd_ev), .pre_val(psc_pre_q), .tick(tick)
  );

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .restart(sw_upd),
    .cnt_wr(cnt_wr), .cnt_wdata(wr_data[CNT_W-1:0]),
    .rl_wr(rl_wr), .rl_wdata(wr_data[CNT_W-1:0]), .rl_buf(ctrl_q.rl_buf),
    .load_act(upd_ev), .cnt(cnt), .rl_pre(rl_pre), .ovf(ovf)
  );

  tmr_sample_div u_div (
    .clk(clk), .rst_n(rst_n), .code(ctrl_q.div), .tick(sample_tick_o)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:   rd_data = DW'(ctrl_q);
      A_STATUS: rd_data = DW'(flag_q);
      A_PSC:    rd_data = DW'(psc_pre_q);
      A_RELOAD: rd_data = DW'(rl_pre);
      A_COUNT: begin
        rd_data = DW'(cnt);
        rd_data[DW-1] = ctrl_q.mirror && flag_q;
      end
      default:  rd_data = '0;
    endcase
  end

  assign upd_pulse_o = upd_q;
  assign flag_o      = flag_q;
endmodule

// File: rtl/tmr_upcount_chk.sv
module tmr_upcount_chk
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DW-1:0]     rd_data,
  input logic              upd_pulse_o,
  input logic              flag_o,
  input logic              sample_tick_o,
  input ctrl_t             ctrl_q,
  input logic [CNT_W-1:0]  cnt
);
  // R2: stopped timer with no register access keeps its count
  a_r2_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !wr_en) |=> $stable(cnt));

  // R4: update-off blocks the pulse of the next cycle
  a_r4_no_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.upd_off |=> !upd_pulse_o);

  // R11: flag stays set unless cleared by a status write
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(wr_en && wr_addr == A_STATUS && wr_data[0])) |=> flag_o);

  // R3: a pulse always leaves the flag set
  a_r3_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    upd_pulse_o |-> flag_o);

  // R7: in single mode the event that pulses has also stopped the timer
  a_r7_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pulse_o && $past(ctrl_q.single) && !$past(wr_en && wr_addr == A_CTRL))
      |-> !ctrl_q.run);

  // R10: code 0 held gives a strobe every cycle
  a_r10_div_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.div == 2'd0 && $past(ctrl_q.div) == 2'd0) |-> sample_tick_o);

  // R12: mirror off keeps bit 31 of a counter read low
  a_r12_mirror_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.mirror && rd_addr == A_COUNT) |-> !rd_data[DW-1]);
endmodule

bind tmr_upcount tmr_upcount_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_addr(rd_addr), .rd_data(rd_data), .upd_pulse_o(upd_pulse_o),
  .flag_o(flag_o), .sample_tick_o(sample_tick_o), .ctrl_q(ctrl_q), .cnt(cnt)
);

// File: tb/sim_tmr_upcount.sv
module sim_tmr_upcount;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        upd_pulse_o, flag_o, sample_tick_o;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_upcount u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .upd_pulse_o(upd_pulse_o),
    .flag_o(flag_o), .sample_tick_o(sample_tick_o)
  );

  // reference model, built from the requirements
  logic [7:0]  m_ctrl;
  logic        m_flag, m_upd;
  logic [15:0] m_psc_pre, m_psc_act, m_pcnt, m_rl_pre, m_rl_act, m_cnt;
  logic [1:0]  m_ph;

  function automatic logic [1:0] lim_of(input logic [1:0] code);
    return (code == 2'd1) ? 2'd1 : (code == 2'd2) ? 2'd3 : 2'd0;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {24'd0, m_ctrl};
      3'd1: return {31'd0, m_flag};
      3'd3: return {16'd0, m_psc_pre};
      3'd4: return {16'd0, m_rl_pre};
      3'd5: return {m_ctrl[7] & m_flag, 15'd0, m_cnt};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R7";
      3'd1: return "R11";
      3'd3: return "R9";
      3'd4: return "R8";
      3'd5: return "R2";
      default: return "R1";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_flag = 0; m_upd = 0; m_psc_pre = '0; m_psc_act = '0;
      m_pcnt = '0; m_rl_pre = 16'hFFFF; m_rl_act = 16'hFFFF; m_cnt = '0; m_ph = '0;
    end else begin
      logic ug, tk, cw, ov, ev;
      ug = wr_en && wr_addr == 3'd2 && wr_data[0];
      tk = m_ctrl[0] && !ug && m_pcnt == m_psc_act;
      cw = wr_en && wr_addr == 3'd5;
      ov = tk && !cw && m_cnt == m_rl_act;
      ev = !m_ctrl[1] && (ov || (ug && !m_ctrl[2]));
      m_upd = ev;
      m_ph = (m_ph >= lim_of(m_ctrl[6:5])) ? 2'd0 : m_ph + 2'd1;
      if (ug) m_pcnt = '0;
      else if (m_ctrl[0]) m_pcnt = (m_pcnt == m_psc_act) ? 16'd0 : m_pcnt + 16'd1;
      if (ug) m_cnt = '0;
      else if (cw) m_cnt = wr_data[15:0];
      else if (tk) m_cnt = (m_cnt == m_rl_act) ? 16'd0 : m_cnt + 16'd1;
      if (wr_en && wr_addr == 3'd4 && !m_ctrl[4]) m_rl_act = wr_data[15:0];
      else if (ev) m_rl_act = m_rl_pre;
      if (ev) m_psc_act = m_psc_pre;
      if (wr_en && wr_addr == 3'd4) m_rl_pre = wr_data[15:0];
      if (wr_en && wr_addr == 3'd3) m_psc_pre = wr_data[15:0];
      if (ev) m_flag = 1;
      else if (wr_en && wr_addr == 3'd1 && wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 3'd0) m_ctrl = wr_data[7:0];
      else if (m_ctrl[3] && ev) m_ctrl[0] = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // one cycle: compare against the model at the falling edge, then drive
  task automatic cyc(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                     input logic [2:0] ra);
    @(negedge clk);
    chk(req_of(rd_addr), rd_data, exp_rd(rd_addr));
    chk("R3", {31'd0, upd_pulse_o}, {31'd0, m_upd});
    chk("R11", {31'd0, flag_o}, {31'd0, m_flag});
    chk("R10", {31'd0, sample_tick_o}, {31'd0, m_ph >= lim_of(m_ctrl[6:5])});
    wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, rd_addr);
  endtask

  task automatic peek(input logic [2:0] a, input string req, input logic [31:0] exp);
    cyc(1'b0, 3'd0, 32'd0, a);
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values
    peek(3'd0, "R1", 32'h0);
    peek(3'd1, "R1", 32'h0);
    peek(3'd4, "R1", 32'h0000_FFFF);
    peek(3'd5, "R1", 32'h0);
    chk("R1", {31'd0, upd_pulse_o}, 32'd0);
    // R4, R5: update request while updates are off and a reload is buffered
    wr(3'd0, 32'h12);          // upd_off + rl_buf, stopped
    wr(3'd4, 32'h5);
    wr(3'd5, 32'h7);
    wr(3'd2, 32'h1);
    peek(3'd5, "R5", 32'h0);
    peek(3'd1, "R4", 32'h0);
    // R12: flag raised by an update request, then mirrored
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h1);
    wr(3'd0, 32'h80);
    peek(3'd5, "R12", 32'h8000_0000);
    wr(3'd0, 32'h0);
    peek(3'd5, "R12", 32'h0);
    // R6: overflow-only ignores the request
    wr(3'd1, 32'h1);
    wr(3'd0, 32'h4);
    wr(3'd2, 32'h1);
    peek(3'd1, "R6", 32'h0);
    // R7: single mode stops itself at 0 after overflow of reload 3
    wr(3'd0, 32'h0);
    wr(3'd4, 32'h3);
    wr(3'd0, 32'h9);
    repeat (10) cyc(1'b0, 3'd0, 32'd0, 3'd5);
    peek(3'd0, "R7", 32'h8);
    peek(3'd5, "R7", 32'h0);
    // random phase (R2, R3, R8, R9, R10, R11 compared every cycle)
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      a = 3'($urandom_range(0, 5));
      case (a)
        3'd0: d = {24'd0, 8'($urandom) | (($urandom_range(0, 9) < 8) ? 8'h01 : 8'h00)};
        3'd2: d = 32'($urandom_range(0, 1));
        3'd3: d = 32'($urandom_range(0, 2));
        3'd1: d = 32'($urandom_range(0, 1));
        default: d = 32'($urandom_range(0, 11)) | ($urandom_range(0, 19) == 0 ? 32'hFFFF_0000 : 0);
      endcase
      cyc($urandom_range(0, 9) < 3, a, d, 3'($urandom_range(0, 7)));
    end
    cyc(1'b0, 3'd0, 32'd0, 3'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule